// File: doc/BRIEF.md
# System Reset and Recovery Sequencer

This block decides when the CPU of a small microcontroller may run. It collects every reason for a reset: an asynchronous power-on input, brownout and watchdog requests, a qualified low level on the shared external reset pin, and a self-clearing reset bit set by the debugger. From these it produces a CPU hold signal that lasts for a programmable timeout. While an internally caused reset is in progress, it pulls the reset pin low through an open-drain enable, so that other devices on the board are reset at the same time. It records the cause of the latest reset in a small status register whose bits software clears by writing 1.

The block also sequences wake-up from stop mode. A wake event holds the CPU for a short or a long delay, chosen by whether the crystal oscillator is enabled. The status register is left alone, and a one-cycle pulse tells the oscillator and watchdog control registers to return to their recovery defaults, with the internal oscillator as the clock. Whenever a hold ends, a one-cycle pulse tells the CPU to load its program counter from the reset vector, which holds the high byte at program address 0002H and the low byte at 0003H.

Top module: `rst_seq_ctrl`

## Requirements
- R1: The pin is first passed through a synchronizer and then qualified. A low level on the reset pin sampled on 4 consecutive clock edges starts a reset with the normal timeout and no pin drive. A low level lasting 3 edges or fewer starts no reset.
- R2: While the reset pin reads low, the CPU stays held even after the timeout has run out. Once the pin is driven high before a clock edge, the hold drops at the third edge that follows.
- R3: A reset caused by the pin leaves status bit 3 set and all other status bits clear.
- R4: A brownout or watchdog request raises the CPU hold and the pin drive together for exactly RST_CYCLES cycles, starting at the edge that samples the request.
- R5: A debugger set pulse raises the debugger reset bit for one cycle. The bit then clears itself when the reset it causes is accepted. That reset drives the pin, lasts RST_CYCLES cycles, and sets status bit 0.
- R6: A stop-mode wake while the CPU is running holds the CPU for SMR_IPO_CYCLES cycles when the crystal is disabled, and for SMR_XTAL_CYCLES cycles when it is enabled. The pin is never driven during this hold.
- R7: A stop-mode recovery leaves the status bits unchanged and raises the control-register init output for exactly one cycle, in the cycle after the wake is accepted.
- R8: The vector fetch output is high for exactly one cycle after any hold ends, in the first cycle where the CPU hold is low.
- R9: Status bits are sticky. A bit is cleared only by writing 1 to its clear input, and writing 0 has no effect. Each new reset replaces the status with its own single bit: bit 0 for power-on or debugger, bit 1 for brownout, bit 2 for watchdog, bit 3 for the pin.
- R10: When requests arrive on the same edge, brownout beats watchdog, watchdog beats the pin, and the pin beats the debugger. Power-on overrides all of them.
- R11: A new reset request that arrives during a hold restarts the full timeout from the edge that samples it.
- R12: The power-on input resets the block asynchronously. Status becomes 0001 and both the hold and the pin drive are active. The hold ends RST_CYCLES cycles after power-on is released.
- R13: A stop-mode wake that arrives while the CPU is already held is ignored. It neither extends the hold nor pulses the control-register init output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_rst_i | input | 1 | Power-on reset, active high, asynchronous |
| bor_req_i | input | 1 | Brownout reset request |
| wdt_req_i | input | 1 | Watchdog reset request |
| rst_pin_n_i | input | 1 | Level read back from the external reset pin, active low |
| rst_pin_drive_o | output | 1 | Open-drain enable that pulls the reset pin low |
| dbg_rst_set_i | input | 1 | Debugger write that sets the reset bit |
| dbg_rst_bit_o | output | 1 | Debugger reset bit, clears itself |
| stop_wake_i | input | 1 | Stop-mode wake event |
| xtal_en_i | input | 1 | Crystal oscillator enabled, selects the long recovery delay |
| stat_clr_i | input | 4 | Write-1-to-clear strobes for the status bits |
| stat_flags_o | output | 4 | Reset cause status bits |
| cpu_hold_o | output | 1 | Holds the CPU in reset |
| vec_fetch_o | output | 1 | One-cycle request to load the PC from the reset vector |
| smr_ctl_init_o | output | 1 | One-cycle pulse that returns the oscillator and watchdog control to recovery defaults |

## Verification
The bench builds the block with RST_CYCLES at 20, SMR_IPO_CYCLES at 66, SMR_XTAL_CYCLES lowered to 300, QUAL_LEN at 4 and SYNC_STAGES at 2. The short system timeout lets the bench hold the pin low for far longer than the timeout, so the release path that waits on the pin gets exercised. It also leaves room to inject a second request in the middle of a hold. The reduced crystal delay keeps the long recovery path cheap while still being clearly different from the short one. The qualification length of 4 places the boundary between a 3-edge and a 4-edge pulse, and the bench drives both sides of it.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
   localparam int FLAG_W = 4;

   typedef enum logic [2:0] {
      SRC_POR = 3'd0,
      SRC_BOR = 3'd1,
      SRC_WDT = 3'd2,
      SRC_EXT = 3'd3,
      SRC_DBG = 3'd4,
      SRC_SMR = 3'd5
   } rst_src_e;

   // status bit that a given cause leaves behind
   function automatic logic [FLAG_W-1:0] flag_of(rst_src_e s);
      case (s)
         SRC_BOR: flag_of = 4'b0010;
         SRC_WDT: flag_of = 4'b0100;
         SRC_EXT: flag_of = 4'b1000;
         default: flag_of = 4'b0001;
      endcase
   endfunction

   // causes that pull the pin low to reset the rest of the board
   function automatic logic drives_pin(rst_src_e s);
      drives_pin = !(s == SRC_EXT || s == SRC_SMR);
   endfunction
endpackage

// File: rtl/rstc_pin_qual.sv
module rstc_pin_qual #(
   parameter int SYNC_STAGES = 2,
   parameter int QUAL_LEN    = 4
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic pin_n_i,
   output logic pin_high_o,
   output logic ext_req_o
);
   localparam int RUN_W = $clog2(QUAL_LEN + 1);
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(QUAL_LEN);
   localparam logic [RUN_W-1:0] RUN_HIT = RUN_W'(QUAL_LEN - 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("rstc_pin_qual: SYNC_STAGES must be at least 2");
   end
   if (QUAL_LEN < 3 || QUAL_LEN > 4) begin : g_bad_qual
      $error("rstc_pin_qual: QUAL_LEN must be 3 or 4");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic [RUN_W-1:0]       run_q;

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) sync_q <= '1;
      else       sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n_i};
   end

   assign pin_high_o = sync_q[SYNC_STAGES-1];

   // consecutive low samples, saturating so a held pin asks only once
   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i)                run_q <= '0;
      else if (pin_high_o)      run_q <= '0;
      else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
   end

   assign ext_req_o = !pin_high_o && (run_q == RUN_HIT);

   AST_QUAL_LOW_RUN: assert property (@(posedge clk_i) disable iff (rst_i)
      ext_req_o |-> (!pin_high_o && !$past(pin_high_o) && !$past(pin_high_o, 2))); // R1
   AST_QUAL_ONCE: assert property (@(posedge clk_i) disable iff (rst_i)
      ext_req_o |=> !ext_req_o); // R1
endmodule

// File: rtl/rstc_src_arb.sv
module rstc_src_arb
   import rstc_pkg::*;
(
   input  logic     bor_i,
   input  logic     wdt_i,
   input  logic     ext_i,
   input  logic     dbg_i,
   output logic     req_o,
   output rst_src_e src_o
);
   always_comb begin
      req_o = bor_i | wdt_i | ext_i | dbg_i;
      if (bor_i)      src_o = SRC_BOR;
      else if (wdt_i) src_o = SRC_WDT;
      else if (ext_i) src_o = SRC_EXT;
      else            src_o = SRC_DBG;
   end
endmodule

// File: rtl/rstc_countdown.sv
module rstc_countdown #(
   parameter int CNT_W   = 8,
   parameter int RST_VAL = 1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             zero_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i)              cnt_q <= CNT_W'(RST_VAL);
      else if (load_i)        cnt_q <= load_val_i;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   AST_CNT_PARKS: assert property (@(posedge clk_i) disable iff (rst_i)
      (zero_o && !load_i) |=> zero_o); // R11
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
   import rstc_pkg::*;
#(
   parameter int RST_CYCLES      = 66,
   parameter int SMR_IPO_CYCLES  = 66,
   parameter int SMR_XTAL_CYCLES = 5000,
   parameter int QUAL_LEN        = 4,
   parameter int SYNC_STAGES     = 2
) (
   input  logic              clk_i,
   input  logic              por_rst_i,
   input  logic              bor_req_i,
   input  logic              wdt_req_i,
   input  logic              rst_pin_n_i,
   output logic              rst_pin_drive_o,
   input  logic              dbg_rst_set_i,
   output logic              dbg_rst_bit_o,
   input  logic              stop_wake_i,
   input  logic              xtal_en_i,
   input  logic [FLAG_W-1:0] stat_clr_i,
   output logic [FLAG_W-1:0] stat_flags_o,
   output logic              cpu_hold_o,
   output logic              vec_fetch_o,
   output logic              smr_ctl_init_o
);
   localparam int MAX_A   = (RST_CYCLES > SMR_IPO_CYCLES) ? RST_CYCLES : SMR_IPO_CYCLES;
   localparam int MAX_CYC = (MAX_A > SMR_XTAL_CYCLES) ? MAX_A : SMR_XTAL_CYCLES;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);
   localparam logic [CNT_W-1:0] LD_SYS  = CNT_W'(RST_CYCLES - 1);
   localparam logic [CNT_W-1:0] LD_IPO  = CNT_W'(SMR_IPO_CYCLES - 1);
   localparam logic [CNT_W-1:0] LD_XTAL = CNT_W'(SMR_XTAL_CYCLES - 1);

   if (RST_CYCLES < 2 || SMR_IPO_CYCLES < 2 || SMR_XTAL_CYCLES < 2) begin : g_bad_delay
      $error("rst_seq_ctrl: every delay must be at least 2 cycles");
   end

   logic              pin_high, ext_req, arb_req, tmr_zero;
   rst_src_e          arb_src, src_q;
   logic              hold_q, dbg_q, vec_q, smr_q;
   logic [FLAG_W-1:0] flags_q;
   logic              smr_start, release_now, tmr_load;
   logic [CNT_W-1:0]  tmr_val;

   // own drive is masked so the block never qualifies its own pulse
   rstc_pin_qual #(.SYNC_STAGES(SYNC_STAGES), .QUAL_LEN(QUAL_LEN)) u_qual (
      .clk_i(clk_i), .rst_i(por_rst_i), .pin_n_i(rst_pin_n_i | rst_pin_drive_o),
      .pin_high_o(pin_high), .ext_req_o(ext_req));

   rstc_src_arb u_arb (
      .bor_i(bor_req_i), .wdt_i(wdt_req_i), .ext_i(ext_req), .dbg_i(dbg_q),
      .req_o(arb_req), .src_o(arb_src));

   assign smr_start   = !hold_q && stop_wake_i && !arb_req;
   assign release_now = hold_q && tmr_zero && pin_high && !arb_req;
   assign tmr_load    = arb_req | smr_start;
   assign tmr_val     = arb_req ? LD_SYS : (xtal_en_i ? LD_XTAL : LD_IPO);

   rstc_countdown #(.CNT_W(CNT_W), .RST_VAL(RST_CYCLES)) u_cnt (
      .clk_i(clk_i), .rst_i(por_rst_i), .load_i(tmr_load),
      .load_val_i(tmr_val), .zero_o(tmr_zero));

   always_ff @(posedge clk_i or posedge por_rst_i) begin
      if (por_rst_i) begin
         hold_q  <= 1'b1;
         src_q   <= SRC_POR;
         flags_q <= flag_of(SRC_POR);
         dbg_q   <= 1'b0;
         vec_q   <= 1'b0;
         smr_q   <= 1'b0;
      end else begin
         vec_q <= release_now;
         smr_q <= smr_start;
         if (dbg_rst_set_i) dbg_q <= 1'b1;
         else if (arb_req)  dbg_q <= 1'b0;
         if (arb_req) flags_q <= flag_of(arb_src);
         else         flags_q <= flags_q & ~stat_clr_i;
         if (arb_req) begin
            hold_q <= 1'b1;
            src_q  <= arb_src;
         end else if (smr_start) begin
            hold_q <= 1'b1;
            src_q  <= SRC_SMR;
         end else if (release_now) begin
            hold_q <= 1'b0;
         end
      end
   end

   assign cpu_hold_o      = hold_q;
   assign rst_pin_drive_o = hold_q && drives_pin(src_q);
   assign dbg_rst_bit_o   = dbg_q;
   assign stat_flags_o    = flags_q;
   assign vec_fetch_o     = vec_q;
   assign smr_ctl_init_o  = smr_q;

   AST_PIN_LOW_HOLDS: assert property (@(posedge clk_i) disable iff (por_rst_i)
      (cpu_hold_o && !pin_high) |=> cpu_hold_o); // R2
   AST_DRIVE_IN_RESET: assert property (@(posedge clk_i) disable iff (por_rst_i)
      rst_pin_drive_o |-> cpu_hold_o); // R4
   AST_DBG_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (por_rst_i)
      (dbg_rst_bit_o && !dbg_rst_set_i) |=> !dbg_rst_bit_o); // R5
   AST_SMR_FLAGS_KEEP: assert property (@(posedge clk_i) disable iff (por_rst_i)
      smr_ctl_init_o |-> (stat_flags_o == ($past(stat_flags_o) & ~$past(stat_clr_i)))); // R7
   AST_VEC_AFTER_HOLD: assert property (@(posedge clk_i) disable iff (por_rst_i)
      vec_fetch_o |-> (!cpu_hold_o && $past(cpu_hold_o))); // R8
   AST_VEC_SINGLE: assert property (@(posedge clk_i) disable iff (por_rst_i)
      vec_fetch_o |=> !vec_fetch_o); // R8
   AST_FLAGS_ONEHOT: assert property (@(posedge clk_i) disable iff (por_rst_i)
      $onehot0(stat_flags_o)); // R9
   AST_BOR_WINS: assert property (@(posedge clk_i) disable iff (por_rst_i)
      (bor_req_i && wdt_req_i) |=> (stat_flags_o == 4'b0010)); // R10
   AST_STOP_IGNORED: assert property (@(posedge clk_i) disable iff (por_rst_i)
      (cpu_hold_o && stop_wake_i) |=> !smr_ctl_init_o); // R13
endmodule

// File: tb/rst_seq_ctrl_tb.sv
module rst_seq_ctrl_tb;
   localparam int RST  = 20;
   localparam int IPO  = 66;
   localparam int XT   = 300;
   localparam int Q    = 4;

   logic clk = 1'b0;
   logic por = 1'b1, bor = 1'b0, wdt = 1'b0, ext_n = 1'b1;
   logic dbg_set = 1'b0, wake = 1'b0, xtal = 1'b0;
   logic [3:0] clr = 4'b0;
   logic pin_n, drive, dbg_bit, cpu_hold, vec_fetch, smr_init;
   logic [3:0] flags;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   string cur_req = "R12";

   always #2.5 clk = ~clk;

   assign pin_n = ext_n & ~drive;

   rst_seq_ctrl #(.RST_CYCLES(RST), .SMR_IPO_CYCLES(IPO), .SMR_XTAL_CYCLES(XT),
                  .QUAL_LEN(Q), .SYNC_STAGES(2)) u_dut (
      .clk_i(clk), .por_rst_i(por), .bor_req_i(bor), .wdt_req_i(wdt),
      .rst_pin_n_i(pin_n), .rst_pin_drive_o(drive), .dbg_rst_set_i(dbg_set),
      .dbg_rst_bit_o(dbg_bit), .stop_wake_i(wake), .xtal_en_i(xtal),
      .stat_clr_i(clr), .stat_flags_o(flags), .cpu_hold_o(cpu_hold),
      .vec_fetch_o(vec_fetch), .smr_ctl_init_o(smr_init));

   // behavioural reference: cause codes 0 por,1 bor,2 wdt,3 pin,4 dbg,5 stop
   bit m_hold = 1, m_dbg = 0, m_vec = 0, m_smr = 0, m_s1 = 1, m_s2 = 1;
   int m_src = 0, m_cnt = RST, m_low = 0;
   logic [3:0] m_flags = 4'b0001;

   function automatic bit m_drive();
      return m_hold && m_src != 3 && m_src != 5;
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (por) begin
         m_hold = 1; m_src = 0; m_cnt = RST; m_flags = 4'b0001;
         m_dbg = 0; m_vec = 0; m_smr = 0; m_s1 = 1; m_s2 = 1; m_low = 0;
      end else begin
         bit pinm, ext, rel, smr;
         int req;
         pinm = ext_n | m_drive();
         ext  = !m_s2 && m_low == Q - 1;
         req  = bor ? 1 : wdt ? 2 : ext ? 3 : m_dbg ? 4 : -1;
         rel  = m_hold && m_cnt == 0 && m_s2 && req < 0;
         smr  = !m_hold && wake && req < 0;
         m_low = m_s2 ? 0 : (m_low == Q ? Q : m_low + 1);
         m_s2 = m_s1;
         m_s1 = pinm;
         if (req >= 0) m_flags = (req == 4) ? 4'b0001 : 4'(1 << req);
         else          m_flags = m_flags & ~clr;
         m_dbg = dbg_set ? 1'b1 : (req >= 0 ? 1'b0 : m_dbg);
         m_vec = rel;
         m_smr = smr;
         if (req >= 0) begin
            m_hold = 1; m_src = req; m_cnt = RST - 1;
         end else if (smr) begin
            m_hold = 1; m_src = 5; m_cnt = (xtal ? XT : IPO) - 1;
         end else begin
            if (m_cnt > 0) m_cnt--;
            if (rel) m_hold = 0;
         end
      end
   end

   task automatic chk(string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", cur_req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      chk("cpu_hold", int'(cpu_hold), int'(m_hold));
      chk("pin_drive", int'(drive), int'(m_drive()));
      chk("status", int'(flags), int'(m_flags));
      chk("dbg_bit", int'(dbg_bit), int'(m_dbg));
      chk("vec_fetch", int'(vec_fetch), int'(m_vec));
      chk("smr_ctl_init", int'(smr_init), int'(m_smr));
   end

   always @(posedge clk) begin
      if (cyc > 150000) begin
         errors++;
         $display("FAIL %s watchdog: actual=%0d cycles expected=below 150000", cur_req, cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic clear_pulses();
      bor = 0; wdt = 0; dbg_set = 0; wake = 0; clr = 4'b0;
   endtask

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1; clear_pulses();
      end
   endtask

   // counts held and driven cycles until the hold falls
   task automatic measure(output int hc, output int dc);
      hc = 0; dc = 0;
      for (int i = 0; i < 2000; i++) begin
         bit h;
         @(negedge clk);
         h = cpu_hold;
         if (h) hc++;
         if (drive) dc++;
         #1; clear_pulses();
         if (!h && hc > 0) break;
      end
   endtask

   initial begin
      int hc, dc;
      // R12: power-on
      step(3);
      chk("R12 status at power-on", int'(flags), 1);
      chk("R12 hold at power-on", int'(cpu_hold), 1);
      por = 0;
      measure(hc, dc);
      chk("R12 hold length", hc, RST);
      chk("R12 drive length", dc, RST);
      chk("R8 vector pulse", int'(vec_fetch), 1);

      // R9: write-1-to-clear
      cur_req = "R9";
      clr = 4'b0001; step(2);
      chk("R9 cleared", int'(flags), 0);

      // R1: a 3-edge pulse is rejected
      cur_req = "R1";
      ext_n = 0; step(3); ext_n = 1;
      step(12);
      chk("R1 short pulse hold", int'(cpu_hold), 0);
      chk("R1 short pulse status", int'(flags), 0);
      // R1: a 4-edge pulse is accepted
      ext_n = 0; step(4); ext_n = 1;
      measure(hc, dc);
      chk("R1 pin reset hold", hc, RST);
      chk("R1 pin reset no drive", dc, 0);
      cur_req = "R3";
      chk("R3 pin status", int'(flags), 8);

      // R2: pin held low well past the timeout
      cur_req = "R2";
      ext_n = 0; step(60);
      chk("R2 still held", int'(cpu_hold), 1);
      ext_n = 1;
      measure(hc, dc);
      chk("R2 release latency", hc, 2);
      chk("R8 vector after pin", int'(vec_fetch), 1);

      // R4: brownout then watchdog
      cur_req = "R4";
      bor = 1; measure(hc, dc);
      chk("R4 bor hold", hc, RST);
      chk("R4 bor drive", dc, RST);
      wdt = 1; measure(hc, dc);
      chk("R4 wdt hold", hc, RST);
      chk("R4 wdt drive", dc, RST);

      // R9: zeros ignored, ones clear
      cur_req = "R9";
      clr = 4'b1011; step(2);
      chk("R9 other bits cleared no effect", int'(flags), 4);
      bor = 1; measure(hc, dc);
      chk("R9 replaced by bor", int'(flags), 2);

      // R5: debugger reset
      cur_req = "R5";
      dbg_set = 1; step(1);
      chk("R5 bit set", int'(dbg_bit), 1);
      measure(hc, dc);
      chk("R5 hold", hc, RST);
      chk("R5 drive", dc, RST);
      chk("R5 status", int'(flags), 1);
      chk("R5 bit cleared", int'(dbg_bit), 0);

      // R10: priority
      cur_req = "R10";
      bor = 1; wdt = 1; measure(hc, dc);
      chk("R10 bor over wdt", int'(flags), 2);
      dbg_set = 1; step(1);
      wdt = 1; measure(hc, dc);
      chk("R10 wdt over dbg", int'(flags), 4);
      chk("R10 wdt over dbg hold", hc, RST);
      chk("R10 dbg dropped", int'(dbg_bit), 0);

      // R11: restart during a hold
      cur_req = "R11";
      wdt = 1; step(10);
      bor = 1; measure(hc, dc);
      chk("R11 restarted hold", hc, RST);
      chk("R11 status", int'(flags), 2);
      wdt = 1; measure(hc, dc);

      // R6 / R7: stop recovery, short then long
      cur_req = "R6";
      xtal = 0; wake = 1; measure(hc, dc);
      chk("R6 ipo hold", hc, IPO);
      chk("R6 no drive", dc, 0);
      cur_req = "R7";
      chk("R7 status kept", int'(flags), 4);
      cur_req = "R6";
      xtal = 1; wake = 1; measure(hc, dc);
      chk("R6 xtal hold", hc, XT);
      xtal = 0;

      // R13: wake during a hold is ignored
      cur_req = "R13";
      wake = 1; step(5);
      wake = 1; measure(hc, dc);
      chk("R13 hold not extended", hc, IPO - 5);
      cur_req = "R8";
      chk("R8 vector after stop", int'(vec_fetch), 1);
      step(1);
      chk("R8 vector single", int'(vec_fetch), 0);
      step(3);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule